// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block drives the carrier-sense and collision outputs that an Ethernet PHY presents on its media independent interface. It takes two activity flags from inside the PHY, one for transmit and one for receive. It also takes the duplex setting, the line speed and a heartbeat enable. From these it forms both outputs. All inputs and both outputs belong to the 25 MHz reference clock domain.

The duplex setting decides how the activity flags combine. In half duplex, transmit and receive each raise carrier sense, and overlapping activity raises collision. In full duplex, only receive activity counts for carrier sense and collision stays low. At 10 Mb/s in half duplex with the heartbeat enabled, the block also adds a signal-quality-error test on the collision line. This is a pulse of about one microsecond that starts when a transmission ends.

Top module: `mii_csc_gen`

## Requirements
- R1: With `full_dplx`=0 (half duplex), `crs` is 1 whenever `tx_act` or `rx_act` is 1, at either value of `spd_100`.
- R2: With `full_dplx`=1 (full duplex), `crs` equals `rx_act`. Transmit activity on its own leaves `crs` at 0.
- R3: With `full_dplx`=0, `col` is 1 whenever `tx_act` and `rx_act` are both 1, at either speed.
- R4: With `full_dplx`=1, `col` is 0 at both speeds, and a falling edge of `tx_act` makes no heartbeat pulse.
- R5: With `full_dplx`=0, `spd_100`=0 (10 Mb/s) and `hb_en`=1, a falling edge of `tx_act` makes `col` high for exactly `HB_CYC` consecutive clock cycles (25 with the default parameters, which is 1 µs at 25 MHz). The pulse starts on the first output update after the edge.
- R6: With `spd_100`=1 (100 Mb/s) or `hb_en`=0, no heartbeat pulse appears on `col`.
- R7: If `full_dplx` goes to 1 while a heartbeat pulse is running, `col` is 0 from the next clock cycle on, and the pulse does not resume.
- R8: While a heartbeat pulse runs, `col` is the OR of the pulse and the real collision. A transmission that starts and ends during the pulse does not restart or lengthen it.
- R9: Both outputs are registered, so a change on the inputs appears one clock cycle later. While `rst_n` is 0, both outputs are 0 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, to be released synchronously |
| tx_act | input | 1 | Transmit activity flag |
| rx_act | input | 1 | Receive activity flag |
| full_dplx | input | 1 | 1 = full duplex, 0 = half duplex |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hb_en | input | 1 | 1 = heartbeat (SQE test) enabled |
| crs | output | 1 | Carrier sense, active high |
| col | output | 1 | Collision detect, active high |

## Verification
The checker tests the cycle-to-cycle rules on every clock:
- carrier sense in both duplex modes;
- a real collision in half duplex;
- collision held low in full duplex, which also covers the abort of a running pulse;
- no collision without a real one when the speed is 100 Mb/s or the heartbeat is disabled.

Some properties cover a whole window of cycles, and only the bench scenarios can show them:
- the exact heartbeat length and the cycle in which it starts;
- the fact that a pulse overlapped by a real collision and a second transmission is neither restarted nor lengthened;
- the reset behaviour.

// File: rtl/mii_csc_pkg.sv
package mii_csc_pkg;

  typedef struct packed {
    logic half;   // half duplex: tx counts for carrier, collisions possible
    logic hb_ok;  // heartbeat pulse permitted in this configuration
  } csc_mode_t;

  // Number of reference-clock cycles covering a duration in ns (rounded up).
  function automatic int unsigned hb_cycles(int unsigned clk_mhz, int unsigned dur_ns);
    return (clk_mhz * dur_ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/csc_mode_dec.sv
module csc_mode_dec
  import mii_csc_pkg::*;
(
  input  logic      full_dplx,
  input  logic      spd_100,
  input  logic      hb_en,
  output csc_mode_t mode
);

  always_comb begin
    mode.half  = ~full_dplx;
    mode.hb_ok = ~full_dplx & ~spd_100 & hb_en;
  end

endmodule

// File: rtl/csc_hb_timer.sv
module csc_hb_timer #(
  parameter int unsigned HB_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic hb_ok,
  output logic hb_on
);

  localparam int unsigned CW = (HB_CYC < 2) ? 1 : $clog2(HB_CYC);
  localparam logic [CW-1:0] LOAD = CW'(HB_CYC - 1);

  logic          tx_d_q, tx_d_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          fall, idle, start;

  always_comb begin
    fall     = tx_d_q & ~tx_act;
    idle     = (cnt_q == '0);
    start    = hb_ok & fall & idle;
    tx_d_nxt = tx_act;
    if (!hb_ok)
      cnt_nxt = '0;
    else if (start)
      cnt_nxt = LOAD;
    else if (!idle)
      cnt_nxt = cnt_q - 1'b1;
    else
      cnt_nxt = cnt_q;
    hb_on = hb_ok & (start | ~idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_d_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tx_d_q <= tx_d_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/mii_csc_gen.sv
module mii_csc_gen
  import mii_csc_pkg::*;
#(
  parameter int unsigned REF_MHZ = 25,
  parameter int unsigned HB_NS   = 1000,
  localparam int unsigned HB_CYC = hb_cycles(REF_MHZ, HB_NS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic rx_act,
  input  logic full_dplx,
  input  logic spd_100,
  input  logic hb_en,
  output logic crs,
  output logic col
);

  csc_mode_t mode;
  logic      hb_on;
  logic      crs_q, crs_nxt;
  logic      col_q, col_nxt;

  csc_mode_dec u_dec (
    .full_dplx (full_dplx),
    .spd_100   (spd_100),
    .hb_en     (hb_en),
    .mode      (mode)
  );

  csc_hb_timer #(.HB_CYC(HB_CYC)) u_hb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_act (tx_act),
    .hb_ok  (mode.hb_ok),
    .hb_on  (hb_on)
  );

  always_comb begin
    crs_nxt = rx_act | (mode.half & tx_act);
    col_nxt = mode.half & ((tx_act & rx_act) | hb_on);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      crs_q <= crs_nxt;
      col_q <= col_nxt;
    end
  end

  assign crs = crs_q;
  assign col = col_q;

endmodule

// File: rtl/mii_csc_chk.sv
module mii_csc_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_act,
  input logic rx_act,
  input logic full_dplx,
  input logic spd_100,
  input logic hb_en,
  input logic crs,
  input logic col
);

  p_half_crs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !full_dplx |=> (crs == ($past(tx_act) | $past(rx_act))));

  p_full_crs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_dplx |=> (crs == $past(rx_act)));

  p_half_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dplx && tx_act && rx_act) |=> col);

  // also covers R7: an aborted pulse never shows after full duplex is set
  p_full_col_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_dplx |=> !col);

  p_no_hb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((spd_100 || !hb_en) && !(tx_act && rx_act)) |=> !col);

  always_comb begin
    if (!rst_n) begin
      p_reset_out_r9: assert (!crs && !col || $isunknown({crs, col}));
    end
  end

endmodule

bind mii_csc_gen mii_csc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_act    (tx_act),
  .rx_act    (rx_act),
  .full_dplx (full_dplx),
  .spd_100   (spd_100),
  .hb_en     (hb_en),
  .crs       (crs),
  .col       (col)
);

// File: tb/sim_mii_csc_gen.sv
module sim_mii_csc_gen;

  localparam int HB = 25;

  logic clk = 1'b0;
  logic rst_n, tx_act, rx_act, full_dplx, spd_100, hb_en;
  logic crs, col;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  mii_csc_gen u0 (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .full_dplx(full_dplx), .spd_100(spd_100), .hb_en(hb_en),
    .crs(crs), .col(col)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic fd, input logic s100, input logic hb);
    @(negedge clk);
    full_dplx = fd; spd_100 = s100; hb_en = hb;
    tx_act = 1'b0; rx_act = 1'b0;
    repeat (HB + 5) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tx_act = 1'b1; rx_act = 1'b1;
    full_dplx = 1'b0; spd_100 = 1'b0; hb_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 crs in reset", crs, 0);
    chk("R9 col in reset", col, 0);
    tx_act = 1'b0; rx_act = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 crs after reset", crs, 0);
    chk("R9 col after reset", col, 0);
  endtask

  task automatic t_half;
    for (int s = 0; s < 2; s++) begin
      cfg(1'b0, s[0], 1'b0);
      for (int p = 0; p < 4; p++) begin
        tx_act = p[1]; rx_act = p[0];
        #1;
        if (p == 3) chk("R9 latency col", col, 0);
        @(negedge clk);
        chk("R1 half crs", crs, int'(p[1] | p[0]));
        chk("R3 half col", col, int'(p[1] & p[0]));
      end
      tx_act = 1'b0; rx_act = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_full;
    int hi;
    for (int s = 0; s < 2; s++) begin
      cfg(1'b1, s[0], 1'b1);
      for (int p = 0; p < 4; p++) begin
        tx_act = p[1]; rx_act = p[0];
        @(negedge clk);
        chk("R2 full crs", crs, int'(p[0]));
        chk("R4 full col", col, 0);
      end
      tx_act = 1'b1; rx_act = 1'b0;
      repeat (3) @(negedge clk);
      tx_act = 1'b0;
      hi = 0;
      for (int i = 0; i < HB + 5; i++) begin
        @(negedge clk);
        if (col) hi++;
      end
      chk("R4 no heartbeat in full", hi, 0);
    end
  endtask

  task automatic t_hb;
    int hi, first_lo;
    cfg(1'b0, 1'b0, 1'b1);
    tx_act = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 no pulse during tx", col, 0);
    tx_act = 1'b0;
    hi = 0; first_lo = -1;
    for (int i = 0; i < HB + 10; i++) begin
      @(negedge clk);
      if (col) hi++;
      else if (first_lo < 0) first_lo = i;
    end
    chk("R5 pulse length", hi, HB);
    chk("R5 pulse first low sample", first_lo, HB);
  endtask

  task automatic t_no_hb;
    int hi;
    for (int k = 0; k < 2; k++) begin
      if (k == 0) cfg(1'b0, 1'b1, 1'b1);
      else        cfg(1'b0, 1'b0, 1'b0);
      tx_act = 1'b1;
      repeat (3) @(negedge clk);
      tx_act = 1'b0;
      hi = 0;
      for (int i = 0; i < HB + 5; i++) begin
        @(negedge clk);
        if (col) hi++;
      end
      chk(k == 0 ? "R6 no pulse at 100" : "R6 no pulse hb off", hi, 0);
    end
  endtask

  task automatic t_abort;
    int hi;
    cfg(1'b0, 1'b0, 1'b1);
    tx_act = 1'b1;
    repeat (3) @(negedge clk);
    tx_act = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 pulse running", col, 1);
    full_dplx = 1'b1;
    @(negedge clk);
    chk("R7 col low after duplex change", col, 0);
    full_dplx = 1'b0;
    hi = 0;
    for (int i = 0; i < HB + 5; i++) begin
      @(negedge clk);
      if (col) hi++;
    end
    chk("R7 pulse does not resume", hi, 0);
  endtask

  task automatic t_overlap;
    int hi, first_lo;
    cfg(1'b0, 1'b0, 1'b1);
    tx_act = 1'b1;
    repeat (3) @(negedge clk);
    tx_act = 1'b0;
    hi = 0; first_lo = -1;
    for (int i = 0; i < HB + 10; i++) begin
      @(negedge clk);
      if (col) hi++;
      else if (first_lo < 0) first_lo = i;
      if (i == 4) begin tx_act = 1'b1; rx_act = 1'b1; end
      if (i == 7) begin tx_act = 1'b0; rx_act = 1'b0; end
    end
    chk("R8 overlapped pulse length", hi, HB);
    chk("R8 no restart first low", first_lo, HB);
  endtask

  initial begin
    t_reset();
    t_half();
    t_full();
    t_hb();
    t_no_hb();
    t_abort();
    t_overlap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule